// File: doc/BRIEF.md
# Request/Grant Bus Handoff Controller

This controller lets up to two outside bus masters borrow the host's local bus. Each master owns one active-low line. It signals over that line with single-clock pulses. A low pulse from the master asks for the bus. The controller answers with a one-clock low grant pulse, and from the next clock it floats the host's bus outputs and holds the bus sequencer off. A second low pulse from the same master hands the bus back. The host drives again on the clock after that pulse. After that, one clock must pass before another grant can be issued.

The controller only releases the bus at points where this is safe. The bus sequencer reports its current phase, whether a locked instruction is running, and two qualifiers for the cycle in progress. If the bus is idle, a pending request is granted at once. During a bus cycle, the grant comes at the cycle's last clock, and only if the request came early enough and the cycle is not the first half of a split transfer. While lock is held, requests are stored but not granted. The pin-level tri-state drivers and the bus cycle generator sit outside this block. The sensed line and the driven grant appear as separate ports.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: A grant is only driven while `bus_phase` is idle (code 0) or the final clock of a cycle (code 5). Phase codes: 0 idle, 1 first, 2 second, 3 third, 4 wait, 5 final.
- R2: Suppose a master pulses its line low for one clock while the bus is idle and free. The controller then drives that channel's `gnt_drive_n` bit low for exactly the next clock.
- R3: `bus_float` is high from the clock after a grant until the clock in which the owning master's release pulse is sampled, inclusive. `seq_holdoff` is high in the grant clock and in every clock where `bus_float` is high.
- R4: If both channels are pending when a grant slot opens, channel 0 (bit 0) is granted first. Channel 1 stays pending.
- R5: A request sampled during phase 1 or 2 of a cycle is granted in that cycle's phase 5 clock. A request sampled in phase 3, 4 or 5 is deferred to phase 5 of the following cycle.
- R6: No grant is given in a phase 5 clock while `word_lo_cycle` or `ack_first_cycle` is high. The request stays pending.
- R7: While `lock_active` is high, no grant is given. Requests are still recorded and granted at the first allowed slot after lock falls.
- R8: The clock after a release has `bus_float` low, `seq_holdoff` low and no grant, even when another request is pending.
- R9: A request pulse from the non-owning channel during a hold is kept pending and granted after the idle clock. Such a pulse does not end the current hold.
- R10: While `rst_n` is low, and right after it rises, all grant bits are high and `bus_float` and `seq_holdoff` are low. Pending requests are discarded by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rq_line_n | input | 2 | Sensed level of each master's request/release line, active low |
| bus_phase | input | 3 | Current bus state code from the sequencer |
| lock_active | input | 1 | A locked instruction is executing |
| word_lo_cycle | input | 1 | Current cycle is the first byte of a two-byte transfer |
| ack_first_cycle | input | 1 | Current cycle is the first interrupt-acknowledge cycle |
| gnt_drive_n | output | 2 | Grant pulse per channel, active low, one clock |
| bus_float | output | 1 | Float the host's bus and control outputs |
| seq_holdoff | output | 1 | Block the sequencer from starting new cycles |

## Verification
Several events can fall into the same clock. Both channels can pulse in one clock. A non-owner request can arrive while the owner still holds the bus, and it is then pending at the very clock the release is taken. In both cases the bench requires channel 0 to win. The other channel must surface only after exactly one empty clock. A third collision pairs a stored request with lock or a split-transfer qualifier in the final phase. There the grant must slip to the next legal slot and must not be lost.

// File: rtl/bh_pkg.sv
package bh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } bus_phase_e;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_HELD = 2'd1,
    ST_GAP  = 2'd2
  } own_state_e;

endpackage

// File: rtl/bh_line_sense.sv
module bh_line_sense #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] line_n,
  output logic [NCH-1:0] line_fall
);

  // one flop per line; a pulse is the high-to-low step seen at the edge
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= line_n[g];
    end

    assign line_fall[g] = prev_q & ~line_n[g];
  end

endmodule

// File: rtl/bh_release_gate.sv
module bh_release_gate
  import bh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] phase_i,
  input  logic       lock_i,
  input  logic       word_lo_i,
  input  logic       ack_first_i,
  input  logic       any_pend_i,
  input  logic       any_req_i,
  output logic       slot_ok_o
);

  bus_phase_e ph;
  logic       arm_q, arm_d;

  assign ph = bus_phase_e'(phase_i);

  // arm: a request was present during the early part of this cycle
  always_comb begin
    arm_d = arm_q;
    if (ph == PH_T4 || ph == PH_IDLE)
      arm_d = 1'b0;
    else if ((ph == PH_T1 || ph == PH_T2) && (any_pend_i || any_req_i))
      arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  always_comb begin
    slot_ok_o = 1'b0;
    if (!lock_i) begin
      if (ph == PH_IDLE)
        slot_ok_o = 1'b1;
      else if (ph == PH_T4 && arm_q && !word_lo_i && !ack_first_i)
        slot_ok_o = 1'b1;
    end
  end

  // R5
  arm_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T3 && !arm_q) |=> !arm_q);

endmodule

// File: rtl/bh_owner_fsm.sv
module bh_owner_fsm
  import bh_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] line_fall,
  input  logic           slot_ok,
  output logic [NCH-1:0] req_evt,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] gnt_n,
  output logic           float_o,
  output logic           holdoff_o
);

  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;

  own_state_e     st_q;
  logic [IDW-1:0] owner_q, sel;
  logic [NCH-1:0] pend_q, clr;
  logic           grant_now, release_evt;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) sel = IDW'(i);
  end

  assign grant_now   = (st_q == ST_FREE) && (|pend_q) && slot_ok;
  assign release_evt = (st_q == ST_HELD) && line_fall[owner_q];
  assign clr         = grant_now ? (NCH'(1) << sel) : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign gnt_n[g]   = ~(grant_now && (sel == IDW'(g)));
    assign req_evt[g] = line_fall[g]
                        && !((st_q == ST_HELD) && (owner_q == IDW'(g)))
                        && !(grant_now && (sel == IDW'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_FREE;
      owner_q <= '0;
      pend_q  <= '0;
    end else begin
      pend_q <= (pend_q | req_evt) & ~clr;
      unique case (st_q)
        ST_FREE: if (grant_now) begin
                   st_q    <= ST_HELD;
                   owner_q <= sel;
                 end
        ST_HELD: if (release_evt) st_q <= ST_GAP;
        ST_GAP:  st_q <= ST_FREE;
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign pend      = pend_q;
  assign float_o   = (st_q == ST_HELD);
  assign holdoff_o = float_o | grant_now;

  // R4
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R2
  gnt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n)) |=> (&gnt_n));

  // R3
  float_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n)) |=> float_o);

  // R9
  float_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (float_o && !(|line_fall)) |=> float_o);

  // R8
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(float_o) |-> ((&gnt_n) && !holdoff_o));

endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
  import bh_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rq_line_n,
  input  logic [2:0]     bus_phase,
  input  logic           lock_active,
  input  logic           word_lo_cycle,
  input  logic           ack_first_cycle,
  output logic [NCH-1:0] gnt_drive_n,
  output logic           bus_float,
  output logic           seq_holdoff
);

  logic [NCH-1:0] fall, req_evt, pend;
  logic           slot_ok;

  bh_line_sense #(.NCH(NCH)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_n    (rq_line_n),
    .line_fall (fall)
  );

  bh_release_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (bus_phase),
    .lock_i      (lock_active),
    .word_lo_i   (word_lo_cycle),
    .ack_first_i (ack_first_cycle),
    .any_pend_i  (|pend),
    .any_req_i   (|req_evt),
    .slot_ok_o   (slot_ok)
  );

  bh_owner_fsm #(.NCH(NCH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_fall (fall),
    .slot_ok   (slot_ok),
    .req_evt   (req_evt),
    .pend      (pend),
    .gnt_n     (gnt_drive_n),
    .float_o   (bus_float),
    .holdoff_o (seq_holdoff)
  );

  // R1
  grant_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_drive_n)) |-> (bus_phase == PH_IDLE || bus_phase == PH_T4));

  // R7
  grant_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_drive_n)) |-> !lock_active);

  // R6
  grant_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!(&gnt_drive_n)) && bus_phase == PH_T4) |-> (!word_lo_cycle && !ack_first_cycle));

endmodule

// File: tb/bus_handoff_ctrl_tb.sv
module bus_handoff_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int NV    = 64;

  // {phase[3], lock, word_lo, ack_first, rq_n[2], exp_gnt_n[2], exp_float, exp_hold}
  localparam logic [11:0] VEC [NV] = '{
    12'b000_0_0_0_10_11_0_0, 12'b000_0_0_0_11_10_0_1, 12'b000_0_0_0_11_11_1_1,
    12'b000_0_0_0_10_11_1_1, 12'b000_0_0_0_11_11_0_0,
    12'b000_0_0_0_00_11_0_0, 12'b000_0_0_0_11_10_0_1, 12'b000_0_0_0_11_11_1_1,
    12'b000_0_0_0_10_11_1_1, 12'b000_0_0_0_11_11_0_0, 12'b000_0_0_0_11_01_0_1,
    12'b000_0_0_0_11_11_1_1, 12'b000_0_0_0_01_11_1_1, 12'b000_0_0_0_11_11_0_0,
    12'b001_0_0_0_11_11_0_0, 12'b010_0_0_0_10_11_0_0, 12'b011_0_0_0_11_11_0_0,
    12'b101_0_0_0_11_10_0_1, 12'b000_0_0_0_11_11_1_1, 12'b000_0_0_0_10_11_1_1,
    12'b000_0_0_0_11_11_0_0,
    12'b001_0_0_0_11_11_0_0, 12'b010_0_0_0_11_11_0_0, 12'b011_0_0_0_10_11_0_0,
    12'b101_0_0_0_11_11_0_0, 12'b001_0_0_0_11_11_0_0, 12'b011_0_0_0_11_11_0_0,
    12'b101_0_0_0_11_10_0_1, 12'b000_0_0_0_11_11_1_1, 12'b000_0_0_0_10_11_1_1,
    12'b000_0_0_0_11_11_0_0,
    12'b001_0_0_0_10_11_0_0, 12'b010_0_1_0_11_11_0_0, 12'b011_0_1_0_11_11_0_0,
    12'b101_0_1_0_11_11_0_0, 12'b001_0_0_0_11_11_0_0, 12'b010_0_0_0_11_11_0_0,
    12'b011_0_0_0_11_11_0_0, 12'b101_0_0_0_11_10_0_1, 12'b000_0_0_0_11_11_1_1,
    12'b000_0_0_0_10_11_1_1, 12'b000_0_0_0_11_11_0_0,
    12'b001_0_0_1_01_11_0_0, 12'b101_0_0_1_11_11_0_0, 12'b000_0_0_0_11_01_0_1,
    12'b000_0_0_0_11_11_1_1, 12'b000_0_0_0_01_11_1_1, 12'b000_0_0_0_11_11_0_0,
    12'b000_1_0_0_10_11_0_0, 12'b000_1_0_0_11_11_0_0, 12'b000_0_0_0_11_10_0_1,
    12'b000_0_0_0_11_11_1_1, 12'b000_0_0_0_10_11_1_1, 12'b000_0_0_0_11_11_0_0,
    12'b000_0_0_0_10_11_0_0, 12'b000_0_0_0_11_10_0_1, 12'b000_0_0_0_01_11_1_1,
    12'b000_0_0_0_10_11_1_1, 12'b000_0_0_0_11_11_0_0, 12'b000_0_0_0_11_01_0_1,
    12'b000_0_0_0_11_11_1_1, 12'b000_0_0_0_01_11_1_1, 12'b000_0_0_0_11_11_0_0,
    12'b000_0_0_0_11_11_0_0
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rq_line_n = 2'b11;
  logic [2:0] bus_phase = 3'd0;
  logic       lock_active = 1'b0;
  logic       word_lo_cycle = 1'b0;
  logic       ack_first_cycle = 1'b0;
  logic [1:0] gnt_drive_n;
  logic       bus_float, seq_holdoff;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  bus_handoff_ctrl #(.NCH(2)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .rq_line_n       (rq_line_n),
    .bus_phase       (bus_phase),
    .lock_active     (lock_active),
    .word_lo_cycle   (word_lo_cycle),
    .ack_first_cycle (ack_first_cycle),
    .gnt_drive_n     (gnt_drive_n),
    .bus_float       (bus_float),
    .seq_holdoff     (seq_holdoff)
  );

  function automatic string tag_of(int i);
    if (i < 5)  return "R2 R3 R8";
    if (i < 14) return "R4 R8";
    if (i < 21) return "R1 R5";
    if (i < 31) return "R5";
    if (i < 42) return "R6";
    if (i < 48) return "R6 R1";
    if (i < 54) return "R7";
    return "R9";
  endfunction

  task automatic check(string tag, logic [1:0] eg, logic ef, logic eh);
    n_chk++;
    if (gnt_drive_n !== eg || bus_float !== ef || seq_holdoff !== eh) begin
      n_bad++;
      $display("FAIL %s: gnt=%b float=%b hold=%b expected gnt=%b float=%b hold=%b",
               tag, gnt_drive_n, bus_float, seq_holdoff, eg, ef, eh);
    end
  endtask

  task automatic drive(logic [2:0] ph, logic [1:0] rq);
    @(negedge clk);
    bus_phase = ph;
    rq_line_n = rq;
    lock_active = 1'b0;
    word_lo_cycle = 1'b0;
    ack_first_cycle = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state, with a request pulse that reset must swallow
    repeat (2) @(negedge clk);
    #1 check("R10 in reset", 2'b11, 1'b0, 1'b0);
    rq_line_n = 2'b10;
    @(negedge clk);
    rq_line_n = 2'b11;
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R10 after release", 2'b11, 1'b0, 1'b0);
    drive(3'd0, 2'b11);
    check("R10 no stale request", 2'b11, 1'b0, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_phase       = VEC[i][11:9];
      lock_active     = VEC[i][8];
      word_lo_cycle   = VEC[i][7];
      ack_first_cycle = VEC[i][6];
      rq_line_n       = VEC[i][5:4];
      #1 check(tag_of(i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R10: reset in the middle of a hold drops float and the pending request
    drive(3'd0, 2'b10);
    drive(3'd0, 2'b11);
    check("R2 directed grant", 2'b10, 1'b0, 1'b1);
    drive(3'd0, 2'b01);
    check("R3 held", 2'b11, 1'b1, 1'b1);
    drive(3'd0, 2'b11);
    rst_n = 1'b0;
    #1 check("R10 reset during hold", 2'b11, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd0, 2'b11);
    check("R10 pending cleared", 2'b11, 1'b0, 1'b0);
    drive(3'd0, 2'b11);
    check("R10 pending cleared 2", 2'b11, 1'b0, 1'b0);

    // R1: a stored request is not granted in wait or third phase
    drive(3'd1, 2'b10);
    drive(3'd3, 2'b11);
    check("R1 third phase", 2'b11, 1'b0, 1'b0);
    drive(3'd4, 2'b11);
    check("R1 wait phase", 2'b11, 1'b0, 1'b0);
    drive(3'd5, 2'b11);
    check("R1 final phase", 2'b10, 1'b0, 1'b1);
    drive(3'd0, 2'b10);
    check("R3 float during release clock", 2'b11, 1'b1, 1'b1);
    drive(3'd0, 2'b11);
    check("R8 gap", 2'b11, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule